// File: doc/BRIEF.md
# Real-Time Clock Register Access Port

This block is the byte-wide host port of a real-time clock. It decodes a 3-bit address qualified by an active-high chip select, an active-low read strobe and an active-low write strobe. A write is taken on the rising (trailing) edge of the write strobe. It is turned into a one-cycle strobe aimed at one time counter, one alarm latch, the control register, or the freeze logic. The time counters and the alarm latches for seconds, minutes and hours share addresses. The steering bit of the control register decides which of the two a write reaches, and the same write also turns the alarm on or off. Reads return the live counter values supplied from outside, or the two interrupt-source flags at the control address.

A second job is to keep the time stable while software reads or loads it. A dummy write to address 1 arms a freeze. Any one-second tick that arrives while the freeze is armed is held back. It is released as a single tick when chip select drops or when a timeout of about 250 ms (set by a parameter in clock cycles) runs out. The control and strobe pins are plain level or pulse signals with no handshake, because every target accepts a strobe in the cycle it appears.

Top module: `rtc_bus_if`

## Requirements
- R1: After reset all write strobes and `tick_out` are low, `ctrl_q` is 0x00, `alarm_en` is low, and `rdata_oe` is low while chip select is low.
- R2: A write is accepted only on a rising edge of `wr_n` seen with `cs`=1 and `rd_n`=1. It gives a one-cycle strobe in the clock cycle after that edge is sampled, with `wr_byte` holding the data. With `cs`=0 or `rd_n`=0 no strobe occurs and no state changes.
- R3: With `ctrl_q` bit 3 equal to 0, a write to address 2, 3 or 4 pulses `cnt_we` bit 0, 1 or 2 and clears `alarm_en`. With bit 3 equal to 1, the same write pulses `alm_we` bit 0, 1 or 2 instead and sets `alarm_en`.
- R4: Writes to address 5 (day) and 6 (month) always pulse `cnt_we` bit 3 or 4, whatever bit 3 holds, and leave `alarm_en` unchanged.
- R5: A write to address 7 pulses `ctrl_we` and loads `ctrl_q` with the byte. The fields are: bits 1:0 prescaler select, bit 2 run, bit 3 steering, bits 7:4 clock-out select.
- R6: A read of address 2 to 6 returns seconds, minutes, hours, day and month counter inputs, whatever bit 3 holds. A read of address 7 returns `{st_alarm, st_clk, 6'b0}`, and a read of address 0 or 1 returns 0x00.
- R7: `rdata_oe` is high only while `cs`=1 and `rd_n`=0. `rdata` is 0x00 whenever `rdata_oe` is low.
- R8: With no freeze armed, each `tick_raw` pulse gives a `tick_out` pulse one cycle later.
- R9: An accepted write to address 1 arms the freeze with no other strobe. While it is armed `tick_out` stays low. When `cs` is then seen falling, the freeze releases and a held tick comes out as one pulse in the cycle after.
- R10: Any number of ticks arriving during one freeze yields exactly one `tick_out` pulse.
- R11: An armed freeze releases by itself TIMEOUT_CYC cycles after arming, even with `cs` held high, and delivers a held tick then.
- R12: An accepted write to address 0 produces no strobe and changes neither `ctrl_q` nor `alarm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, taken on rising edge |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| cnt_sec | input | 8 | Seconds counter value (BCD) |
| cnt_min | input | 8 | Minutes counter value |
| cnt_hour | input | 8 | Hours counter value |
| cnt_day | input | 8 | Day-of-month counter value |
| cnt_mon | input | 8 | Month counter value |
| st_alarm | input | 1 | Alarm interrupt-source flag |
| st_clk | input | 1 | Clock-out interrupt-source flag |
| tick_raw | input | 1 | One-cycle pulse from the one-second prescaler |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Data drive enable |
| cnt_we | output | 5 | Counter load strobes: bit 0 seconds to bit 4 month |
| alm_we | output | 3 | Alarm latch strobes: bit 0 seconds, 1 minutes, 2 hours |
| ctrl_we | output | 1 | Control register write strobe |
| wr_byte | output | 8 | Data byte belonging to the current strobe |
| ctrl_q | output | 8 | Control register contents |
| alarm_en | output | 1 | Alarm compare enable |
| tick_out | output | 1 | Delivered one-second tick |

## Verification
The hardest situation to reach is a tick that lands inside an armed freeze and has to come out exactly once. The bench keeps chip select high after the arming write and pulses the tick twice with a read in between. It then shows that nothing comes out until chip select drops. For the timeout path the bench builds the block with a short timeout, holds chip select high throughout, and counts output pulses in windows before and after the expected release cycle.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int N_CNT      = 5;  // seconds, minutes, hours, day, month
  localparam int N_ALM      = 3;  // seconds, minutes, hours share addresses with counters
  localparam int A_FREEZE   = 1;
  localparam int A_CNT_BASE = 2;
  localparam int A_CTRL     = 7;

  typedef struct packed {
    logic [3:0] clk_sel;
    logic       steer;
    logic       run;
    logic [1:0] presc;
  } ctrl_t;

  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  output logic [N_CNT-1:0]  cnt_we,
  output logic [N_ALM-1:0]  alm_we,
  output logic              ctrl_we,
  output logic              arm_stb,
  output byte_t             wr_byte,
  output byte_t             ctrl_q,
  output logic              alarm_en
);
  logic             wr_n_q;
  logic             acc;
  logic             ctrl_hit;
  logic             arm_hit;
  logic [N_CNT-1:0] cnt_we_d;
  logic [N_ALM-1:0] alm_we_d;
  ctrl_t            ctrl_r;

  // trailing edge of the write strobe, qualified by select and no read
  assign acc      = cs && rd_n && wr_n && !wr_n_q;
  assign ctrl_hit = acc && (addr == ADDR_W'(A_CTRL));
  assign arm_hit  = acc && (addr == ADDR_W'(A_FREEZE));

  for (genvar i = 0; i < N_CNT; i++) begin : g_slot
    logic hit;
    assign hit = acc && (addr == ADDR_W'(A_CNT_BASE + i));
    if (i < N_ALM) begin : g_shared
      assign cnt_we_d[i] = hit && !ctrl_r.steer;
      assign alm_we_d[i] = hit && ctrl_r.steer;
    end else begin : g_cnt_only
      assign cnt_we_d[i] = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q   <= 1'b1;
      cnt_we   <= '0;
      alm_we   <= '0;
      ctrl_we  <= 1'b0;
      arm_stb  <= 1'b0;
      wr_byte  <= '0;
      ctrl_r   <= '0;
      alarm_en <= 1'b0;
    end else begin
      wr_n_q  <= wr_n;
      cnt_we  <= cnt_we_d;
      alm_we  <= alm_we_d;
      ctrl_we <= ctrl_hit;
      arm_stb <= arm_hit;
      if (acc) wr_byte <= wdata;
      if (ctrl_hit) ctrl_r <= ctrl_t'(wdata);
      if (|alm_we_d) alarm_en <= 1'b1;
      else if (|cnt_we_d[N_ALM-1:0]) alarm_en <= 1'b0;
    end
  end

  assign ctrl_q = ctrl_r;

  // R3: a write reaches one target at most
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnt_we, alm_we, ctrl_we, arm_stb}));

  // R3: a latch strobe only follows a write made while steering pointed at latches
  p_latch_steer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|alm_we) |-> $past(ctrl_r.steer));

  // R3: the alarm turns on only together with a latch load
  p_alarm_en_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_en) |-> (|alm_we));

  // R2: every strobe traces back to a selected, non-read cycle with the strobe released
  p_write_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cnt_we) || (|alm_we) || ctrl_we || arm_stb) |->
      ($past(cs) && $past(rd_n) && $past(wr_n)));
endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_bus_pkg::*;
(
  input  logic                   cs,
  input  logic                   rd_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [N_CNT-1:0][DATA_W-1:0] cnt_vals,
  input  logic                   st_alarm,
  input  logic                   st_clk,
  output byte_t                  rdata,
  output logic                   rdata_oe
);
  always_comb begin
    rdata_oe = cs && !rd_n;
    rdata    = '0;
    if (rdata_oe) begin
      if (addr == ADDR_W'(A_CTRL))
        rdata = {st_alarm, st_clk, {(DATA_W-2){1'b0}}};
      for (int i = 0; i < N_CNT; i++)
        if (addr == ADDR_W'(A_CNT_BASE + i)) rdata = cnt_vals[i];
    end
  end
endmodule

// File: rtl/rtc_tick_freeze.sv
module rtc_tick_freeze #(
  parameter int TIMEOUT_CYC = 31_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic arm_stb,
  input  logic tick_raw,
  output logic tick_out
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  logic          armed;
  logic          held;
  logic          cs_q;
  logic [TW-1:0] tmr;
  logic          release_now;

  assign release_now = (cs_q && !cs) || (tmr == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      held     <= 1'b0;
      cs_q     <= 1'b0;
      tmr      <= '0;
      tick_out <= 1'b0;
    end else begin
      cs_q     <= cs;
      tick_out <= 1'b0;
      if (arm_stb) begin
        armed <= 1'b1;
        tmr   <= '0;
        if (tick_raw) held <= 1'b1;
      end else if (armed) begin
        if (release_now) begin
          armed    <= 1'b0;
          held     <= 1'b0;
          tmr      <= '0;
          tick_out <= held || tick_raw;
        end else begin
          tmr <= tmr + 1'b1;
          if (tick_raw) held <= 1'b1;
        end
      end else begin
        tick_out <= tick_raw;
      end
    end
  end

  // R9: no tick leaves while the freeze is armed
  p_no_tick_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> !armed);

  // R11: the timeout counter never passes its last value
  p_timer_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (tmr <= T_LAST));

  // R10: a held tick exists only under an armed freeze
  p_held_scope_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> armed);
endmodule

// File: rtl/rtc_bus_if.sv
module rtc_bus_if
  import rtc_bus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 31_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic [7:0] cnt_sec,
  input  logic [7:0] cnt_min,
  input  logic [7:0] cnt_hour,
  input  logic [7:0] cnt_day,
  input  logic [7:0] cnt_mon,
  input  logic       st_alarm,
  input  logic       st_clk,
  input  logic       tick_raw,
  output logic [7:0] rdata,
  output logic       rdata_oe,
  output logic [4:0] cnt_we,
  output logic [2:0] alm_we,
  output logic       ctrl_we,
  output logic [7:0] wr_byte,
  output logic [7:0] ctrl_q,
  output logic       alarm_en,
  output logic       tick_out
);
  logic                         arm_stb;
  logic [N_CNT-1:0][DATA_W-1:0] cnt_vals;

  assign cnt_vals = {cnt_mon, cnt_day, cnt_hour, cnt_min, cnt_sec};

  rtc_wr_decode u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .wdata    (wdata),
    .cnt_we   (cnt_we),
    .alm_we   (alm_we),
    .ctrl_we  (ctrl_we),
    .arm_stb  (arm_stb),
    .wr_byte  (wr_byte),
    .ctrl_q   (ctrl_q),
    .alarm_en (alarm_en)
  );

  rtc_rd_mux u_rd (
    .cs       (cs),
    .rd_n     (rd_n),
    .addr     (addr),
    .cnt_vals (cnt_vals),
    .st_alarm (st_alarm),
    .st_clk   (st_clk),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  rtc_tick_freeze #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frz (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .arm_stb  (arm_stb),
    .tick_raw (tick_raw),
    .tick_out (tick_out)
  );

  // R7: a cycle driving read data is never followed by a write strobe
  p_no_rw_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |=> !((|cnt_we) || (|alm_we) || ctrl_we));
endmodule

// File: tb/rtc_bus_if_bench.sv
module rtc_bus_if_bench;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] cnt_sec = 8'h59, cnt_min = 8'h07, cnt_hour = 8'h23;
  logic [7:0] cnt_day = 8'h31, cnt_mon = 8'h92;
  logic       st_alarm = 1'b0, st_clk = 1'b0, tick_raw = 1'b0;
  logic [7:0] rdata, wr_byte, ctrl_q;
  logic       rdata_oe, ctrl_we, alarm_en, tick_out;
  logic [4:0] cnt_we;
  logic [2:0] alm_we;

  int errors = 0, checks = 0, pulses = 0;
  bit done = 0;
  logic [4:0] s_cnt; logic [2:0] s_alm; logic s_ctrl; logic [7:0] s_byte;

  always #4 clk = ~clk;

  rtc_bus_if #(.TIMEOUT_CYC(TO)) u_rtc_bus_if (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .cnt_sec(cnt_sec), .cnt_min(cnt_min), .cnt_hour(cnt_hour),
    .cnt_day(cnt_day), .cnt_mon(cnt_mon), .st_alarm(st_alarm), .st_clk(st_clk),
    .tick_raw(tick_raw), .rdata(rdata), .rdata_oe(rdata_oe), .cnt_we(cnt_we),
    .alm_we(alm_we), .ctrl_we(ctrl_we), .wr_byte(wr_byte), .ctrl_q(ctrl_q),
    .alarm_en(alarm_en), .tick_out(tick_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (tick_out) pulses++;
  endtask

  // starts and ends at a negedge; strobes are sampled one cycle after the trailing edge
  task automatic do_write(input logic [2:0] a, input logic [7:0] d, input bit keep,
                          input logic cs_v = 1'b1, input logic rd_v = 1'b1);
    cs = cs_v; rd_n = rd_v; addr = a; wdata = d; wr_n = 1'b0;
    step();
    wr_n = 1'b1;
    step();
    s_cnt = cnt_we; s_alm = alm_we; s_ctrl = ctrl_we; s_byte = wr_byte;
    rd_n = 1'b1;
    if (!keep) cs = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string req,
                         input bit keep);
    cs = 1'b1; rd_n = 1'b0; addr = a;
    #2;
    chk({req, " oe"}, 32'(rdata_oe), 32'd1);
    chk({req, " data"}, 32'(rdata), 32'(exp));
    step();
    rd_n = 1'b1;
    if (!keep) cs = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt_we", 32'(cnt_we), 0);
    chk("R1 alm_we", 32'(alm_we), 0);
    chk("R1 ctrl_q", 32'(ctrl_q), 0);
    chk("R1 alarm_en", 32'(alarm_en), 0);
    chk("R1 tick_out", 32'(tick_out), 0);
    chk("R1 rdata_oe", 32'(rdata_oe), 0);
  endtask

  task automatic t_ctrl();
    do_write(3'd7, 8'hA5, 0);
    chk("R5 ctrl_we", 32'(s_ctrl), 1);
    chk("R5 wr_byte", 32'(s_byte), 32'hA5);
    chk("R5 ctrl_q", 32'(ctrl_q), 32'hA5);
    step();
    chk("R2 strobe one cycle", 32'(ctrl_we), 0);
  endtask

  task automatic t_steer();
    do_write(3'd3, 8'h42, 0);  // steering bit 3 of A5 is 0
    chk("R3 counter min", 32'(s_cnt), 32'b00010);
    chk("R3 no latch", 32'(s_alm), 0);
    chk("R3 alarm off", 32'(alarm_en), 0);
    do_write(3'd7, 8'h08, 0);
    do_write(3'd4, 8'h12, 0);
    chk("R3 latch hour", 32'(s_alm), 32'b100);
    chk("R3 no counter", 32'(s_cnt), 0);
    chk("R3 alarm on", 32'(alarm_en), 1);
    do_write(3'd5, 8'h15, 0);
    chk("R4 day counter", 32'(s_cnt), 32'b01000);
    chk("R4 day no latch", 32'(s_alm), 0);
    do_write(3'd6, 8'h03, 0);
    chk("R4 month counter", 32'(s_cnt), 32'b10000);
    chk("R4 alarm kept", 32'(alarm_en), 1);
    do_write(3'd2, 8'h30, 0);
    chk("R3 latch sec", 32'(s_alm), 32'b001);
    do_write(3'd7, 8'h00, 0);
    do_write(3'd2, 8'h30, 0);
    chk("R3 counter sec", 32'(s_cnt), 32'b00001);
    chk("R3 alarm cleared", 32'(alarm_en), 0);
  endtask

  task automatic t_gating();
    do_write(3'd7, 8'hFF, 0, 1'b0, 1'b1);
    chk("R2 no cs strobe", 32'(s_ctrl), 0);
    chk("R2 no cs ctrl", 32'(ctrl_q), 0);
    do_write(3'd7, 8'hFF, 0, 1'b1, 1'b0);
    chk("R2 rd active strobe", 32'(s_ctrl), 0);
    chk("R2 rd active ctrl", 32'(ctrl_q), 0);
    do_write(3'd7, 8'h08, 0);
    do_write(3'd0, 8'h00, 0);
    chk("R12 addr0 strobes", 32'({s_cnt, s_alm, s_ctrl}), 0);
    chk("R12 addr0 ctrl", 32'(ctrl_q), 32'h08);
    chk("R12 addr0 alarm", 32'(alarm_en), 0);
  endtask

  task automatic t_reads();
    do_read(3'd2, 8'h59, "R6 sec", 0);
    do_read(3'd3, 8'h07, "R6 min", 0);
    do_read(3'd4, 8'h23, "R6 hour", 0);
    do_read(3'd5, 8'h31, "R6 day", 0);
    do_read(3'd6, 8'h92, "R6 month", 0);
    st_alarm = 1'b1; st_clk = 1'b0;
    do_read(3'd7, 8'h80, "R6 status alarm", 0);
    st_alarm = 1'b0; st_clk = 1'b1;
    do_read(3'd7, 8'h40, "R6 status clk", 0);
    do_read(3'd1, 8'h00, "R6 addr1", 0);
    #2;
    chk("R7 oe idle", 32'(rdata_oe), 0);
    chk("R7 data idle", 32'(rdata), 0);
    cs = 1'b1; addr = 3'd2; #1;
    chk("R7 oe cs only", 32'(rdata_oe), 0);
    cs = 1'b0;
  endtask

  task automatic t_tick_pass();
    pulses = 0;
    tick_raw = 1'b1; step();
    chk("R8 tick latency", 32'(tick_out), 1);
    tick_raw = 1'b0; step(); step();
    chk("R8 single pulse", 32'(pulses), 1);
  endtask

  task automatic t_freeze_cs();
    do_write(3'd1, 8'h00, 1);
    chk("R9 arm no strobe", 32'({s_cnt, s_alm, s_ctrl}), 0);
    pulses = 0;
    step();
    tick_raw = 1'b1; step(); tick_raw = 1'b0; step();
    do_read(3'd3, 8'h07, "R9 read while frozen", 1);
    tick_raw = 1'b1; step(); tick_raw = 1'b0; step(); step();
    chk("R9 held while armed", 32'(pulses), 0);
    cs = 1'b0;
    step();
    chk("R9 release on cs fall", 32'(tick_out), 1);
    step(); step(); step();
    chk("R10 exactly one", 32'(pulses), 1);
  endtask

  task automatic t_timeout();
    do_write(3'd1, 8'h00, 1);
    pulses = 0;
    tick_raw = 1'b1; step(); tick_raw = 1'b0;
    repeat (28) step();
    chk("R11 held before timeout", 32'(pulses), 0);
    repeat (20) step();
    chk("R11 released by timeout", 32'(pulses), 1);
    cs = 1'b0;
    repeat (3) step();
    chk("R11 no second release", 32'(pulses), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_steer();
    t_gating();
    t_reads();
    t_tick_pass();
    t_freeze_cs();
    t_timeout();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule